// File: doc/BRIEF.md
# Pipelined Host-Port Memory Read Interface

This block is the device side of a host port through which an external host reads on-chip program memory and data memory over one shared 16-bit multiplexed address/data bus. The host first loads a control word that names the target memory and a start address, then issues short reads. Each short read hands back the word that the previous read prefetched into a one-entry buffer, and starts fetching the next word in the background. The host never waits for the new word, and the bus is free again as soon as the strobes are released.

Program-memory words are 24 bits wide and leave the port as two 16-bit reads: the upper 16 bits first, then the low 8 bits zero-extended. Because of the one-word pipeline, the first read after a new address is a dummy read that only primes the buffer. If the control word is changed while a program-memory word is half transferred, the pending low half is dropped. The port then takes the next data word the host writes as the new control word.

The bus is modelled as separate input, output and output-enable vectors. All host strobes are active low and sampled on the rising clock edge. The two memories are synchronous arrays that the core loads through its own write port.

Top module: `hp_host_rd_port`

## Requirements
- R1: After reset the acknowledge output `hp_ack_n` is 0 (ready), the bus enable is 0, the prefetch buffer holds 0, and the control word selects program memory at address 0 with no half-word or pending-control state.
- R2: `hp_bus_oe` is 1 exactly while `hp_sel_n` and `hp_rd_n` are both 0. With only one of them low, the bus stays undriven and no read starts.
- R3: A read starts at the first rising edge where the port is idle and `hp_sel_n` and `hp_rd_n` are both 0. `hp_ack_n` is then 1 for exactly two cycles and returns to 0 one cycle after the buffer is reloaded. `hp_bus_o` holds one value for the whole read.
- R4: Every read returns the word prefetched by the preceding read. The first read after a control-word change returns whatever the buffer held before the change, so it is a dummy read.
- R5: With the memory-select bit set (data memory), each read prefetches the 16-bit word at the current address and then increments the 14-bit address, wrapping from 0x3FFF to 0. Memory is indexed by the low `MEM_AW` address bits.
- R6: With the memory-select bit clear (program memory), the first prefetch of a word yields bits 23:8 of the word. The next prefetch yields bits 7:0 in bus bits 7:0 with bus bits 15:8 equal to 0. The address increments only after that low half.
- R7: An address-latch cycle (`hp_sel_n`=0, `hp_latch_n`=0, `hp_rd_n`=1, `hp_wr_n`=1) loads the control word from bus bit 14 (memory select) and bits 13:0 (address). Bus bit 15 is ignored. It acts once per cycle, however long the strobe is held.
- R8: An address-latch cycle that arrives while a program-memory low half is still pending discards that half and leaves the control word unchanged. It arms the port so that the next host write cycle (`hp_sel_n`=0, `hp_wr_n`=0) loads the control word from the bus, with the same field layout as R7.
- R9: A core write (`core_ctl_we`) loads the control word from `core_ctl_wdata` (bit 14 select, bits 13:0 address). If a program-memory low half is pending at that time, the half is discarded and the next host write loads the control word as in R8.
- R10: A host write cycle while nothing is armed changes neither the control word nor the read sequence.
- R11: Holding `hp_sel_n` and `hp_rd_n` low after the acknowledge returns starts no further fetch. A new read can start on the clock after both strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_sel_n | input | 1 | Host port select, active low |
| hp_rd_n | input | 1 | Host read strobe, active low |
| hp_wr_n | input | 1 | Host write strobe, active low |
| hp_latch_n | input | 1 | Host address-latch strobe, active low |
| hp_bus_i | input | DATA_W | Value the host drives on the shared bus |
| hp_bus_o | output | DATA_W | Value the port drives on the shared bus |
| hp_bus_oe | output | 1 | Output enable for the bus drivers |
| hp_ack_n | output | 1 | 0 = ready for a cycle, 1 = prefetch in progress |
| core_ctl_we | input | 1 | Core write to the control word |
| core_ctl_wdata | input | ADDR_W+1 | Control word from the core: select bit above address |
| core_mem_we | input | 1 | Core write into one of the memories |
| core_mem_dm | input | 1 | Core write target: 1 = data memory, 0 = program memory |
| core_mem_addr | input | MEM_AW | Core write address |
| core_mem_wdata | input | PM_W | Core write data (data memory takes the low DATA_W bits) |

## Verification
The hardest state to reach from the ports is a program-memory word left half transferred at the moment the control word changes. Reaching it takes an address latch, a dummy read that leaves the low half pending, and only then the interrupting latch or core write. The following host write must also be recognised as a control load rather than ignored. Directed sequences build each variant of this on purpose: an interrupting latch, an interrupting core write, and a stray host write with nothing armed. A seeded random mix of reads, latches, host writes, core control writes and memory rewrites then lands on the same boundary at many addresses. Every returned word is compared with a reference model of the buffer, the half-word state and the pending-control state.

// File: rtl/hp_pkg.sv
package hp_pkg;

    // Read engine phases: idle, memory read in flight, buffer just reloaded,
    // waiting for the host to release its strobes.
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_FETCH  = 2'd1,
        RS_SETTLE = 2'd2,
        RS_HOLD   = 2'd3
    } rd_state_e;

endpackage

// File: rtl/hp_sync_ram.sv
module hp_sync_ram #(
    parameter int WIDTH = 16,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hp_ctl_reg.sv
module hp_ctl_reg #(
    parameter int ADDR_W = 14,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_latch,
    input  logic              host_wr,
    input  logic [ADDR_W:0]   host_word,
    input  logic              core_we,
    input  logic [ADDR_W:0]   core_word,
    input  logic              step,
    input  logic [LO_W-1:0]   lo_in,
    output logic [ADDR_W-1:0] addr,
    output logic              dm,
    output logic              half,
    output logic [LO_W-1:0]   lo,
    output logic              pend
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              dm;
        logic              half;
        logic              pend;
        logic [LO_W-1:0]   lo;
    } ctl_t;

    localparam logic [ADDR_W-1:0] ADDR_INC = {{(ADDR_W-1){1'b0}}, 1'b1};

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;

        // Advance the word pointer after each prefetch.
        if (step) begin
            if (ctl_q.dm) begin
                ctl_d.addr = ctl_q.addr + ADDR_INC;
            end else if (!ctl_q.half) begin
                ctl_d.half = 1'b1;
                ctl_d.lo   = lo_in;
            end else begin
                ctl_d.half = 1'b0;
                ctl_d.addr = ctl_q.addr + ADDR_INC;
            end
        end

        // Host address latch: normal load, or a mid-word interruption.
        if (host_latch) begin
            if (ctl_q.half) begin
                ctl_d.half = 1'b0;
                ctl_d.pend = 1'b1;
            end else begin
                ctl_d.dm   = host_word[ADDR_W];
                ctl_d.addr = host_word[ADDR_W-1:0];
            end
        end

        // Host data word consumed as a control load only when armed.
        if (host_wr && ctl_q.pend) begin
            ctl_d.dm   = host_word[ADDR_W];
            ctl_d.addr = host_word[ADDR_W-1:0];
            ctl_d.half = 1'b0;
            ctl_d.pend = 1'b0;
        end

        // Core write has the last word.
        if (core_we) begin
            ctl_d.dm   = core_word[ADDR_W];
            ctl_d.addr = core_word[ADDR_W-1:0];
            ctl_d.half = 1'b0;
            if (ctl_q.half) begin
                ctl_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign addr = ctl_q.addr;
    assign dm   = ctl_q.dm;
    assign half = ctl_q.half;
    assign lo   = ctl_q.lo;
    assign pend = ctl_q.pend;

    // R6: a pending low half only exists for program memory.
    p_half_pm_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.half |-> !ctl_q.dm);

    // R8 / R9: arming only happens out of a half-transferred word.
    p_pend_after_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.pend) |-> $past(ctl_q.half));

    // R10: with no event the address does not move.
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !host_latch && !host_wr && !core_we) |=> $stable(ctl_q.addr));

endmodule

// File: rtl/hp_rd_engine.sv
module hp_rd_engine
    import hp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PM_W   = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_n,
    input  logic                   rd_n,
    input  logic                   dm,
    input  logic                   half,
    input  logic [PM_W-DATA_W-1:0] lo,
    input  logic [PM_W-1:0]        pm_rdata,
    input  logic [DATA_W-1:0]      dm_rdata,
    output logic                   mem_re,
    output logic                   step,
    output logic                   idle,
    output logic [DATA_W-1:0]      bus_o,
    output logic                   bus_oe,
    output logic                   ack_n
);
    localparam int LO_W  = PM_W - DATA_W;
    localparam int PAD_W = DATA_W - LO_W;

    typedef struct packed {
        rd_state_e         st;
        logic [DATA_W-1:0] pbuf;
        logic [DATA_W-1:0] pout;
    } eng_t;

    eng_t eng_d, eng_q;
    logic rd_req;

    always_comb begin
        eng_d  = eng_q;
        rd_req = !sel_n && !rd_n;
        mem_re = 1'b0;
        step   = 1'b0;

        case (eng_q.st)
            RS_IDLE: begin
                if (rd_req) begin
                    eng_d.st   = RS_FETCH;
                    eng_d.pout = eng_q.pbuf;
                    mem_re     = 1'b1;
                end
            end
            RS_FETCH: begin
                step     = 1'b1;
                eng_d.st = RS_SETTLE;
                if (dm) begin
                    eng_d.pbuf = dm_rdata;
                end else if (half) begin
                    eng_d.pbuf = {{PAD_W{1'b0}}, lo};
                end else begin
                    eng_d.pbuf = pm_rdata[PM_W-1 -: DATA_W];
                end
            end
            RS_SETTLE: begin
                eng_d.st = RS_HOLD;
            end
            RS_HOLD: begin
                if (!rd_req) begin
                    eng_d.st = RS_IDLE;
                end
            end
            default: begin
                eng_d.st = RS_IDLE;
            end
        endcase

        bus_o  = (eng_q.st == RS_IDLE) ? eng_q.pbuf : eng_q.pout;
        bus_oe = rd_req;
        ack_n  = (eng_q.st == RS_FETCH) || (eng_q.st == RS_SETTLE);
        idle   = (eng_q.st == RS_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: RS_IDLE, pbuf: '0, pout: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    // R3: the word on the bus does not change during a read.
    p_bus_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st != RS_IDLE && $past(eng_q.st != RS_IDLE)) |-> $stable(bus_o));

    // R3: acknowledge stays high for two cycles, then drops.
    p_ack_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n) |=> ack_n);
    p_ack_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_n && $past(ack_n)) |=> !ack_n);

    // R4: the buffer only reloads at the end of a fetch.
    p_buf_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st != RS_FETCH) |=> $stable(eng_q.pbuf));

    // R11: a held read strobe does not restart a fetch.
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == RS_HOLD && rd_req) |=> !ack_n);

endmodule

// File: rtl/hp_host_rd_port.sv
module hp_host_rd_port #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int PM_W   = 24,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_sel_n,
    input  logic              hp_rd_n,
    input  logic              hp_wr_n,
    input  logic              hp_latch_n,
    input  logic [DATA_W-1:0] hp_bus_i,
    output logic [DATA_W-1:0] hp_bus_o,
    output logic              hp_bus_oe,
    output logic              hp_ack_n,
    input  logic              core_ctl_we,
    input  logic [ADDR_W:0]   core_ctl_wdata,
    input  logic              core_mem_we,
    input  logic              core_mem_dm,
    input  logic [MEM_AW-1:0] core_mem_addr,
    input  logic [PM_W-1:0]   core_mem_wdata
);
    localparam int LO_W = PM_W - DATA_W;

    typedef struct packed {
        logic latch_prev;
        logic wr_prev;
    } strb_t;

    strb_t strb_d, strb_q;

    logic              idle;
    logic              latch_lvl, wr_lvl;
    logic              latch_pulse, wr_pulse;
    logic              mem_re, step;
    logic [ADDR_W-1:0] addr;
    logic              dm, half, pend;
    logic [LO_W-1:0]   lo;
    logic [PM_W-1:0]   pm_rdata;
    logic [DATA_W-1:0] dm_rdata;
    logic              unused_bits;

    // One-shot detection of latch and write cycles, only between reads.
    always_comb begin
        latch_lvl   = !hp_sel_n && !hp_latch_n && hp_rd_n && hp_wr_n && idle;
        wr_lvl      = !hp_sel_n && !hp_wr_n && hp_rd_n && hp_latch_n && idle;
        latch_pulse = latch_lvl && !strb_q.latch_prev;
        wr_pulse    = wr_lvl && !strb_q.wr_prev;
        strb_d.latch_prev = latch_lvl;
        strb_d.wr_prev    = wr_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= '0;
        end else begin
            strb_q <= strb_d;
        end
    end

    assign unused_bits = ^{hp_bus_i[DATA_W-1:ADDR_W+1], addr[ADDR_W-1:MEM_AW], pend};

    hp_ctl_reg #(
        .ADDR_W (ADDR_W),
        .LO_W   (LO_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_latch (latch_pulse),
        .host_wr    (wr_pulse),
        .host_word  (hp_bus_i[ADDR_W:0]),
        .core_we    (core_ctl_we),
        .core_word  (core_ctl_wdata),
        .step       (step),
        .lo_in      (pm_rdata[LO_W-1:0]),
        .addr       (addr),
        .dm         (dm),
        .half       (half),
        .lo         (lo),
        .pend       (pend)
    );

    hp_sync_ram #(
        .WIDTH (PM_W),
        .AW    (MEM_AW)
    ) u_pm_ram (
        .clk   (clk),
        .we    (core_mem_we && !core_mem_dm),
        .waddr (core_mem_addr),
        .wdata (core_mem_wdata),
        .re    (mem_re),
        .raddr (addr[MEM_AW-1:0]),
        .rdata (pm_rdata)
    );

    hp_sync_ram #(
        .WIDTH (DATA_W),
        .AW    (MEM_AW)
    ) u_dm_ram (
        .clk   (clk),
        .we    (core_mem_we && core_mem_dm),
        .waddr (core_mem_addr),
        .wdata (core_mem_wdata[DATA_W-1:0]),
        .re    (mem_re),
        .raddr (addr[MEM_AW-1:0]),
        .rdata (dm_rdata)
    );

    hp_rd_engine #(
        .DATA_W (DATA_W),
        .PM_W   (PM_W)
    ) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n    (hp_sel_n),
        .rd_n     (hp_rd_n),
        .dm       (dm),
        .half     (half),
        .lo       (lo),
        .pm_rdata (pm_rdata),
        .dm_rdata (dm_rdata),
        .mem_re   (mem_re),
        .step     (step),
        .idle     (idle),
        .bus_o    (hp_bus_o),
        .bus_oe   (hp_bus_oe),
        .ack_n    (hp_ack_n)
    );

    // R7: a held latch strobe yields a single load pulse.
    p_latch_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        latch_pulse |=> !latch_pulse);

    // R3: the acknowledge only rises out of an idle port.
    p_ack_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hp_ack_n) |-> $past(idle));

endmodule

// File: tb/hp_host_rd_port_tb.sv
`timescale 1ns/1ps
module hp_host_rd_port_tb;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 16;
    localparam int PM_W   = 24;
    localparam int MEM_AW = 6;
    localparam int DEPTH  = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hp_sel_n = 1'b1, hp_rd_n = 1'b1, hp_wr_n = 1'b1, hp_latch_n = 1'b1;
    logic [DATA_W-1:0] hp_bus_i = '0;
    logic [DATA_W-1:0] hp_bus_o;
    logic              hp_bus_oe, hp_ack_n;
    logic              core_ctl_we = 1'b0;
    logic [ADDR_W:0]   core_ctl_wdata = '0;
    logic              core_mem_we = 1'b0, core_mem_dm = 1'b0;
    logic [MEM_AW-1:0] core_mem_addr = '0;
    logic [PM_W-1:0]   core_mem_wdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [PM_W-1:0]   pm_m [DEPTH];
    logic [DATA_W-1:0] dm_m [DEPTH];
    logic [ADDR_W-1:0] m_addr = '0;
    logic              m_dm = 1'b0, m_half = 1'b0, m_pend = 1'b0;
    logic [7:0]        m_lo = '0;
    logic [DATA_W-1:0] m_buf = '0;

    always #2 clk = ~clk;

    hp_host_rd_port #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PM_W (PM_W), .MEM_AW (MEM_AW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .hp_sel_n (hp_sel_n), .hp_rd_n (hp_rd_n), .hp_wr_n (hp_wr_n), .hp_latch_n (hp_latch_n),
        .hp_bus_i (hp_bus_i), .hp_bus_o (hp_bus_o), .hp_bus_oe (hp_bus_oe), .hp_ack_n (hp_ack_n),
        .core_ctl_we (core_ctl_we), .core_ctl_wdata (core_ctl_wdata),
        .core_mem_we (core_mem_we), .core_mem_dm (core_mem_dm),
        .core_mem_addr (core_mem_addr), .core_mem_wdata (core_mem_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pm_upper(input logic [23:0] w);
        return w[23:8];
    endfunction

    function automatic logic [15:0] pm_lower(input logic [7:0] b);
        return {8'h00, b};
    endfunction

    // Model: returns the buffered word and performs the prefetch (R4, R5, R6).
    task automatic model_read(output logic [15:0] ret);
        ret = m_buf;
        if (m_dm) begin
            m_buf  = dm_m[m_addr[MEM_AW-1:0]];
            m_addr = m_addr + 14'd1;
        end else if (!m_half) begin
            m_buf  = pm_upper(pm_m[m_addr[MEM_AW-1:0]]);
            m_lo   = pm_m[m_addr[MEM_AW-1:0]][7:0];
            m_half = 1'b1;
        end else begin
            m_buf  = pm_lower(m_lo);
            m_half = 1'b0;
            m_addr = m_addr + 14'd1;
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic mem_write(input logic dmsel, input int a, input logic [23:0] d);
        core_mem_we = 1'b1; core_mem_dm = dmsel;
        core_mem_addr = MEM_AW'(a); core_mem_wdata = d;
        @(negedge clk);
        core_mem_we = 1'b0;
        if (dmsel) dm_m[a] = d[15:0]; else pm_m[a] = d;
    endtask

    task automatic host_latch(input logic [15:0] w, input int hold);
        hp_sel_n = 1'b0; hp_latch_n = 1'b0; hp_bus_i = w;
        repeat (hold) @(negedge clk);
        hp_sel_n = 1'b1; hp_latch_n = 1'b1;
        @(negedge clk);
        if (m_half) begin
            m_half = 1'b0; m_pend = 1'b1;
        end else begin
            m_dm = w[14]; m_addr = w[13:0];
        end
    endtask

    task automatic host_write(input logic [15:0] w);
        hp_sel_n = 1'b0; hp_wr_n = 1'b0; hp_bus_i = w;
        @(negedge clk);
        hp_sel_n = 1'b1; hp_wr_n = 1'b1;
        @(negedge clk);
        if (m_pend) begin
            m_dm = w[14]; m_addr = w[13:0]; m_half = 1'b0; m_pend = 1'b0;
        end
    endtask

    task automatic core_ctl(input logic [14:0] w);
        core_ctl_we = 1'b1; core_ctl_wdata = w;
        @(negedge clk);
        core_ctl_we = 1'b0;
        m_dm = w[14]; m_addr = w[13:0];
        if (m_half) m_pend = 1'b1;
        m_half = 1'b0;
    endtask

    task automatic host_read(input int hold_extra, input string req);
        logic [15:0] exp;
        logic [15:0] got;
        check("R3 ack low before start", 32'(hp_ack_n), 32'd0);
        model_read(exp);
        hp_sel_n = 1'b0; hp_rd_n = 1'b0;
        #1;
        check("R2 bus enabled during read", 32'(hp_bus_oe), 32'd1);
        @(negedge clk);
        got = hp_bus_o;
        check(req, 32'(got), 32'(exp));
        check("R3 ack high in first fetch cycle", 32'(hp_ack_n), 32'd1);
        @(negedge clk);
        check("R3 ack high in second fetch cycle", 32'(hp_ack_n), 32'd1);
        check("R3 bus stable", 32'(hp_bus_o), 32'(got));
        @(negedge clk);
        check("R3 ack back low", 32'(hp_ack_n), 32'd0);
        check("R3 bus stable at end", 32'(hp_bus_o), 32'(got));
        for (int i = 0; i < hold_extra; i++) begin
            @(negedge clk);
            check("R11 held strobe starts no fetch", 32'(hp_ack_n), 32'd0);
            check("R11 bus stable while held", 32'(hp_bus_o), 32'(got));
        end
        hp_sel_n = 1'b1; hp_rd_n = 1'b1;
        @(negedge clk);
        check("R2 bus released", 32'(hp_bus_oe), 32'd0);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd7411);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ack after reset", 32'(hp_ack_n), 32'd0);
        check("R1 bus disabled after reset", 32'(hp_bus_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int a = 0; a < DEPTH; a++) mem_write(1'b0, a, 24'($urandom()));
        for (int a = 0; a < DEPTH; a++) mem_write(1'b1, a, 24'($urandom()));

        // R1: buffer starts at 0, control selects program memory at 0
        host_read(0, "R1 reset buffer returned");
        host_read(0, "R1 R6 upper half of pm word 0");
        host_read(0, "R1 R6 lower half of pm word 0");

        // R2: a single strobe low drives nothing and starts nothing
        hp_sel_n = 1'b0; #1;
        check("R2 select alone", 32'(hp_bus_oe), 32'd0);
        @(negedge clk);
        check("R2 select alone no fetch", 32'(hp_ack_n), 32'd0);
        hp_sel_n = 1'b1; hp_rd_n = 1'b0; #1;
        check("R2 read strobe alone", 32'(hp_bus_oe), 32'd0);
        @(negedge clk);
        check("R2 read strobe alone no fetch", 32'(hp_ack_n), 32'd0);
        hp_rd_n = 1'b1;
        @(negedge clk);

        // R4, R5: data memory sequence with dummy read
        host_latch(16'h4005, 1);
        host_read(0, "R4 dummy read returns old buffer");
        for (int i = 0; i < 4; i++) host_read(0, "R5 data memory sequence");

        // R5: address wrap
        host_latch(16'h7FFE, 1);
        for (int i = 0; i < 4; i++) host_read(0, "R5 data memory wrap");

        // R6: program memory halves
        host_latch(16'h000A, 1);
        for (int i = 0; i < 6; i++) host_read(0, "R6 program memory halves");

        // R7: bit 15 ignored, long latch strobe acts once
        host_latch(16'hC003, 3);
        for (int i = 0; i < 3; i++) host_read(0, "R7 latch with bit 15 set");

        // R8: latch in the middle of a pm word, then host write loads control
        host_latch(16'h0014, 1);
        host_read(0, "R8 dummy read before interrupt");
        host_latch(16'h401E, 1);
        host_write(16'h4007);
        for (int i = 0; i < 3; i++) host_read(0, "R8 control from host write");

        // R9: core write in the middle of a pm word
        host_latch(16'h0028, 1);
        host_read(0, "R9 dummy read before core write");
        core_ctl(15'h400C);
        for (int i = 0; i < 3; i++) host_read(0, "R9 core control write");
        host_write(16'h0032);
        for (int i = 0; i < 3; i++) host_read(0, "R9 armed host write");

        // R10: stray host write is ignored
        host_latch(16'h400F, 1);
        host_read(0, "R10 dummy read");
        host_write(16'h4021);
        for (int i = 0; i < 3; i++) host_read(0, "R10 write ignored");

        // R11: hold the read strobe past the acknowledge
        host_read(3, "R11 held read");
        host_read(0, "R11 next read after release");

        // Random mix
        for (int k = 0; k < 300; k++) begin
            int op;
            op = $urandom_range(0, 99);
            if (op < 50) begin
                host_read($urandom_range(0, 2), "R4 R5 R6 random read");
            end else if (op < 65) begin
                host_latch({1'b0, 1'($urandom()), 14'($urandom())}, $urandom_range(1, 2));
            end else if (op < 75) begin
                host_write(16'($urandom()));
            end else if (op < 85) begin
                core_ctl(15'($urandom()));
            end else begin
                mem_write(1'($urandom()), $urandom_range(0, DEPTH - 1), 24'($urandom()));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule